// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block guards a small microcontroller against runaway code. A tick source, chosen by a static configuration input as either a slow dedicated oscillator tick (already synchronized into the system clock domain as a one-cycle enable) or the system clock divided by four, advances a prescaler of `PRE_W` bits. The prescaler's carry drives a single final stage. A carry that finds the final stage already set is a timeout. Software clears reset only the final stage. The prescaler keeps its count, so the time left after a clear depends on where the prescaler stood, and the timeout period ranges from 2^PRE_W + 1 to 2^(PRE_W+1) ticks.

In single mode, one clear strobe restarts the watchdog. In paired mode, software must issue both clear strobes, in either order, before the watchdog restarts. A repeat of the strobe already issued does nothing. A halt strobe also clears the watchdog in both modes. A timeout in normal operation raises a one-cycle device reset. A timeout in power-down instead raises a one-cycle pulse that resets only the program counter and stack pointer. Both kinds of timeout set a sticky status flag. The asynchronous active-low reset clears every register, including the flag.

Top module: `wdt_paired_clear`

## Requirements
- R1: With `cfg_src_sel`=0 each cycle with `osc_tick`=1 is one tick. With `cfg_src_sel`=1 one tick occurs every fourth system clock cycle, counted from reset release.
- R2: After reset release, the timeout occurs on tick number 2^(PRE_W+1), which is 128 when PRE_W=6. `dev_rst` is then high for exactly one cycle, in the cycle after the clock edge that took that tick.
- R3: A software clear zeroes only the final stage and leaves the prescaler's count alone. With PRE_W=6, a clear after 100 ticks leads to a timeout 92 ticks later.
- R4: With `cfg_pair_mode`=0, one `clr_single` strobe clears the watchdog, and `clr_one` and `clr_two` have no effect.
- R5: With `cfg_pair_mode`=1, a clear needs one `clr_one` and one `clr_two` in either order. A repeated `clr_one` or `clr_two` has no effect, and `clr_single` has no effect.
- R6: A `halt_req` strobe clears the watchdog in both modes.
- R7: A timeout while `pwr_down`=1 produces a one-cycle `pcsp_rst` and no `dev_rst`.
- R8: `to_flag` rises with the first timeout pulse of either kind and stays high until `rst_n` is asserted.
- R9: While `cfg_wdt_en`=0 the counters hold and every clear and halt strobe is ignored.
- R10: With `cfg_src_sel`=1 and `pwr_down`=1 no ticks occur, so no timeout ever happens.
- R11: While `rst_n` is low, `dev_rst`, `pcsp_rst` and `to_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset that clears all state |
| cfg_wdt_en | input | 1 | Watchdog enable (configuration) |
| cfg_src_sel | input | 1 | Tick source: 0 oscillator tick, 1 system clock / 4 |
| cfg_pair_mode | input | 1 | Clear mode: 0 single strobe, 1 paired strobes |
| osc_tick | input | 1 | Synchronized oscillator tick enable |
| pwr_down | input | 1 | CPU is in power-down |
| clr_single | input | 1 | Single-clear instruction strobe |
| clr_one | input | 1 | First paired-clear instruction strobe |
| clr_two | input | 1 | Second paired-clear instruction strobe |
| halt_req | input | 1 | Halt instruction strobe |
| dev_rst | output | 1 | One-cycle full device reset |
| pcsp_rst | output | 1 | One-cycle program counter and stack pointer reset during power-down |
| to_flag | output | 1 | Sticky timeout status |

## Verification
The hardest effect to observe is the residual prescaler count, because nothing at the ports shows the prescaler directly. The bench makes it visible by issuing clears at chosen tick counts and then measuring how many more ticks pass before the timeout. That figure must match a value worked out from the prescaler position at the time of the clear. A tick is generated every cycle to keep these runs short. The same measurement reveals an ignored strobe: a strobe that is ignored leaves the remaining tick count unchanged, while one wrongly acted on makes the count longer. Paired-mode order and repetition are driven as strobe sequences placed between tick runs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    PAIR_NONE  = 2'd0,
    PAIR_SEEN1 = 2'd1,
    PAIR_SEEN2 = 2'd2
  } pair_state_e;
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic src_sel,
  input  logic pwr_down,
  input  logic osc_tick,
  output logic cnt_tick
);
  localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};
  localparam logic [DIV_W-1:0] DIV_ONE = 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic             run, sys_tick;

  // system clock stops in power-down, so the divider freezes
  always_comb begin
    run      = en && !pwr_down;
    div_d    = div_q;
    if (run) div_d = div_q + DIV_ONE;
    sys_tick = run && (div_q == DIV_MAX);
    cnt_tick = en && (src_sel ? sys_tick : osc_tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/wdt_clear_ctrl.sv
module wdt_clear_ctrl
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pair_mode,
  input  logic clr_single,
  input  logic clr_one,
  input  logic clr_two,
  input  logic halt_req,
  output logic sw_clr
);
  pair_state_e st_q, st_d;
  logic        pair_done;

  always_comb begin
    st_d      = st_q;
    pair_done = 1'b0;
    if (en && pair_mode) begin
      if (clr_one && clr_two) begin
        pair_done = 1'b1;
        st_d      = PAIR_NONE;
      end else begin
        unique case (st_q)
          PAIR_NONE: begin
            if (clr_one)      st_d = PAIR_SEEN1;
            else if (clr_two) st_d = PAIR_SEEN2;
          end
          PAIR_SEEN1: begin
            if (clr_two) begin
              pair_done = 1'b1;
              st_d      = PAIR_NONE;
            end
          end
          PAIR_SEEN2: begin
            if (clr_one) begin
              pair_done = 1'b1;
              st_d      = PAIR_NONE;
            end
          end
          default: st_d = PAIR_NONE;
        endcase
      end
    end
    sw_clr = en && (halt_req || (pair_mode ? pair_done : clr_single));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PAIR_NONE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wdt_divider.sv
module wdt_divider #(
  parameter int PRE_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_tick,
  input  logic clr,
  output logic timeout_evt
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};
  localparam logic [PRE_W-1:0] PRE_ONE = 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             fin_q, fin_d;
  logic             carry;

  always_comb begin
    pre_d = pre_q;
    if (cnt_tick) pre_d = pre_q + PRE_ONE;
    carry       = cnt_tick && (pre_q == PRE_MAX);
    timeout_evt = carry && fin_q && !clr;
    fin_d       = fin_q;
    if (clr)        fin_d = 1'b0;
    else if (carry) fin_d = !fin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      fin_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      fin_q <= fin_d;
    end
  end
endmodule

// File: rtl/wdt_paired_clear.sv
module wdt_paired_clear #(
  parameter int PRE_W = 15,
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wdt_en,
  input  logic cfg_src_sel,
  input  logic cfg_pair_mode,
  input  logic osc_tick,
  input  logic pwr_down,
  input  logic clr_single,
  input  logic clr_one,
  input  logic clr_two,
  input  logic halt_req,
  output logic dev_rst,
  output logic pcsp_rst,
  output logic to_flag
);
  logic cnt_tick, sw_clr, timeout_evt;
  logic dev_rst_d, pcsp_rst_d, to_flag_d;

  wdt_tick_sel #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_wdt_en),
    .src_sel  (cfg_src_sel),
    .pwr_down (pwr_down),
    .osc_tick (osc_tick),
    .cnt_tick (cnt_tick)
  );

  wdt_clear_ctrl u_clr (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cfg_wdt_en),
    .pair_mode  (cfg_pair_mode),
    .clr_single (clr_single),
    .clr_one    (clr_one),
    .clr_two    (clr_two),
    .halt_req   (halt_req),
    .sw_clr     (sw_clr)
  );

  wdt_divider #(.PRE_W(PRE_W)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_tick    (cnt_tick),
    .clr         (sw_clr),
    .timeout_evt (timeout_evt)
  );

  always_comb begin
    dev_rst_d  = timeout_evt && !pwr_down;
    pcsp_rst_d = timeout_evt && pwr_down;
    to_flag_d  = to_flag || timeout_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_rst  <= 1'b0;
      pcsp_rst <= 1'b0;
      to_flag  <= 1'b0;
    end else begin
      dev_rst  <= dev_rst_d;
      pcsp_rst <= pcsp_rst_d;
      to_flag  <= to_flag_d;
    end
  end
endmodule

// File: rtl/wdt_paired_clear_chk.sv
module wdt_paired_clear_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_wdt_en,
  input logic pwr_down,
  input logic dev_rst,
  input logic pcsp_rst,
  input logic to_flag
);
  AST_DEVRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> !dev_rst); // R2
  AST_PCSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pcsp_rst |=> !pcsp_rst); // R7
  AST_RESET_KIND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rst && pcsp_rst)); // R7
  AST_PCSP_IN_PWRDN: assert property (@(posedge clk) disable iff (!rst_n)
    pcsp_rst |-> $past(pwr_down)); // R7
  AST_DEVRST_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |-> !$past(pwr_down)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag |=> to_flag); // R8
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst || pcsp_rst) |-> to_flag); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wdt_en) |-> (!dev_rst && !pcsp_rst)); // R9
endmodule

bind wdt_paired_clear wdt_paired_clear_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wdt_en (cfg_wdt_en),
  .pwr_down   (pwr_down),
  .dev_rst    (dev_rst),
  .pcsp_rst   (pcsp_rst),
  .to_flag    (to_flag)
);

// File: tb/tb_wdt_paired_clear.sv
module tb_wdt_paired_clear;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n, cfg_wdt_en, cfg_src_sel, cfg_pair_mode, osc_tick, pwr_down;
  logic clr_single, clr_one, clr_two, halt_req;
  logic dev_rst, pcsp_rst, to_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  wdt_paired_clear #(.PRE_W(W), .DIV_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wdt_en(cfg_wdt_en), .cfg_src_sel(cfg_src_sel),
    .cfg_pair_mode(cfg_pair_mode), .osc_tick(osc_tick), .pwr_down(pwr_down),
    .clr_single(clr_single), .clr_one(clr_one), .clr_two(clr_two), .halt_req(halt_req),
    .dev_rst(dev_rst), .pcsp_rst(pcsp_rst), .to_flag(to_flag)
  );

  // op codes: 0 none, 1 single clear, 2 clear-1, 3 clear-2, 4 halt
  typedef struct packed {
    logic       pair;
    logic [7:0] pre_ticks;
    logic [2:0] op_a;
    logic [2:0] op_b;
    logic [8:0] exp_ticks;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,   3'd0, 3'd0, 9'd128}, // R2 full period from reset
    '{1'b0, 8'd100, 3'd1, 3'd0, 9'd92},  // R3 R4 residual prescaler
    '{1'b1, 8'd70,  3'd2, 3'd2, 9'd58},  // R5 repeat has no effect
    '{1'b1, 8'd70,  3'd2, 3'd3, 9'd122}, // R5 clear-1 then clear-2
    '{1'b1, 8'd70,  3'd3, 3'd2, 9'd122}, // R5 clear-2 then clear-1
    '{1'b0, 8'd70,  3'd2, 3'd3, 9'd58},  // R4 paired strobes ignored
    '{1'b1, 8'd70,  3'd1, 3'd0, 9'd58},  // R5 single strobe ignored
    '{1'b0, 8'd100, 3'd4, 3'd0, 9'd92},  // R6 halt, single mode
    '{1'b1, 8'd100, 3'd4, 3'd0, 9'd92}   // R6 halt, paired mode
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2, 3, 4, 6: return "R5";
      5: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    osc_tick = 0; clr_single = 0; clr_one = 0; clr_two = 0; halt_req = 0;
    repeat (3) step();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_op(int op);
    clr_single = (op == 1);
    clr_one    = (op == 2);
    clr_two    = (op == 3);
    halt_req   = (op == 4);
    step();
    clr_single = 0; clr_one = 0; clr_two = 0; halt_req = 0;
  endtask

  // returns number of ticks (or cycles) until a timeout pulse, 0 if none
  task automatic count_to_event(int max_n, bit drive_tick, output int n);
    n = 0;
    for (int i = 1; i <= max_n; i++) begin
      osc_tick = drive_tick;
      step();
      if (dev_rst || pcsp_rst) begin
        n = i;
        break;
      end
    end
    osc_tick = 0;
  endtask

  task automatic run_ticks(int k);
    for (int i = 0; i < k; i++) begin
      osc_tick = 1;
      step();
    end
    osc_tick = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    cfg_wdt_en = 1; cfg_src_sel = 0; cfg_pair_mode = 0; pwr_down = 0;
    rst_n = 1'b0;
    osc_tick = 0; clr_single = 0; clr_one = 0; clr_two = 0; halt_req = 0;
    #1;
    step();
    // R11 outputs low during reset
    check("R11 dev_rst", dev_rst, 0);
    check("R11 pcsp_rst", pcsp_rst, 0);
    check("R11 to_flag", to_flag, 0);

    // table of vectors: ticks to timeout after the given strobes
    for (int v = 0; v < NV; v++) begin
      cfg_pair_mode = VECS[v].pair;
      do_reset();
      run_ticks(int'(VECS[v].pre_ticks));
      do_op(int'(VECS[v].op_a));
      do_op(int'(VECS[v].op_b));
      count_to_event(300, 1'b1, n);
      check(vec_req(v), n, int'(VECS[v].exp_ticks));
      check("R2 dev_rst kind", dev_rst, 1);
      step();
      check("R2 dev_rst one cycle", dev_rst, 0);
    end

    // R8 flag sticky, then cleared by reset
    repeat (20) step();
    check("R8 flag held", to_flag, 1);
    rst_n = 1'b0;
    #1;
    check("R11 flag cleared", to_flag, 0);

    // R7 timeout in power-down with oscillator source
    cfg_pair_mode = 0; pwr_down = 1;
    do_reset();
    count_to_event(300, 1'b1, n);
    check("R7 ticks", n, 128);
    check("R7 pcsp_rst", pcsp_rst, 1);
    check("R7 dev_rst", dev_rst, 0);
    check("R8 flag set", to_flag, 1);
    step();
    check("R7 pcsp one cycle", pcsp_rst, 0);

    // R10 divided system clock frozen in power-down
    cfg_src_sel = 1; pwr_down = 1;
    do_reset();
    count_to_event(600, 1'b0, n);
    check("R10 no timeout", n, 0);
    pwr_down = 0;
    // R1 divided clock: 128 ticks at one per four cycles
    count_to_event(700, 1'b0, n);
    check("R1 sysclk/4 cycles", n, 512);
    check("R1 dev_rst", dev_rst, 1);

    // R9 disabled: counting held and strobes ignored
    cfg_src_sel = 0; pwr_down = 0; cfg_pair_mode = 0;
    do_reset();
    run_ticks(100);
    cfg_wdt_en = 0;
    do_op(1);
    do_op(4);
    count_to_event(50, 1'b1, n);
    check("R9 quiet when disabled", n, 0);
    cfg_wdt_en = 1;
    count_to_event(300, 1'b1, n);
    check("R9 strobes ignored", n, 28);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule